// File: doc/BRIEF.md
# Virtual Stripe Sequencer

This block runs an application written as a chain of N pipeline stages on a smaller ring of P physical stripes. Each stripe is a row of 8-bit ALU processing elements that all apply one operation and one 8-bit immediate to their own byte lane of a 32-bit data word. On every clock cycle exactly one stripe is rewritten with the next virtual stage from a small configuration store. The store's read pointer counts modulo N and the stripe pointer counts modulo P. The stripe that is rewritten is always the one whose stage has just been completed, so stages are swapped in and out of the hardware as the data needs them.

Each stripe passes its result to its neighbour in the ring. A stripe that carries stage 0 takes a fresh word from the input stream. A stripe that carries stage N-1 presents its result on the output with a valid flag. Because only P of the N stages are resident at any moment, the block accepts P words in every window of N cycles. The result for each word appears N cycles after the word was taken. The configuration store is written while the block is idle. Holding `go` high streams data. Dropping `go` stops intake and lets the words already in flight finish.

The controller is a three-state machine. In **Idle** the store can be written. **Idle→Run** happens when `go` is high and `stage_cnt` is legal. In **Run** stripes are rewritten and input is taken. **Run→Drain** happens when `go` is low. In **Drain** stripes are still rewritten but no input is taken. **Drain→Idle** happens once no stripe holds a valid word.

Top module: `vstripe_engine`

## Requirements
- R1: After reset the block is in Idle, with `in_take` and `out_valid` both low.
- R2: A write (`cfg_we` high) stores `cfg_op` and `cfg_imm` into the stage slot given by `cfg_addr`, but only while the block is Idle; writes in Run or Drain leave the stored stages unchanged.
- R3: `go` sampled high in Idle starts Run only when `stage_cnt` is between P and 16 inclusive; otherwise the block stays Idle and `in_take` stays low.
- R4: Each byte lane a is transformed independently by the stage's opcode: 0 pass a, 1 a+imm, 2 a-imm (both modulo 256), 3 a AND imm, 4 a OR imm, 5 a XOR imm, 6 a shifted left by imm[2:0], 7 a shifted right logically by imm[2:0].
- R5: Every accepted word produces exactly one output word: the input with stages 0 through N-1 applied in order. Outputs leave in the order the inputs were taken.
- R6: A word taken in cycle c (`in_take` high, `in_data` sampled at the closing edge) is presented with `out_valid` high in cycle c+N.
- R7: Counting the first Run cycle as t=0, `in_take` is high in Run exactly when t mod N is below P, which gives P accepted words per N cycles.
- R8: Each Run or Drain cycle rewrites one stripe. The stripe index advances modulo P and the stage index advances modulo N. The rewritten stripe is the one that held stage (new stage − P) mod N.
- R9: After `go` falls in Run, no further word is taken. Every word already accepted still emerges. The block then returns to Idle, where `in_take` and `out_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration store write strobe |
| cfg_addr | input | 4 | Stage slot to write |
| cfg_op | input | 3 | Opcode for the stage (see R4) |
| cfg_imm | input | 8 | Immediate operand for the stage |
| stage_cnt | input | 5 | Number of virtual stages N, sampled when Run starts |
| go | input | 1 | Hold high to stream; low to drain |
| in_data | input | 32 | Input word, four byte lanes |
| in_take | output | 1 | High in a cycle whose closing edge accepts `in_data` |
| out_valid | output | 1 | `out_data` holds a finished word |
| out_data | output | 32 | Result of the final virtual stage |

## Verification
The embedded properties check, on every cycle, the things that can be seen locally. They check that at most one stripe is at the input head and at most one at the output tail. They check that the stripe being rewritten is the one that finished stage (new − P) mod N. They also check that the stage pointer stays below N, that Run never starts with an illegal depth, that Idle is silent, and that configuration writes land or leave the store untouched. The properties cannot show arithmetic results, the N-cycle latency, output order, the P-of-N intake pattern, or that a drain loses no word. Those need the bench's scenarios, which run many depths and opcode mixes against a reference model and include writes issued mid-run.

// File: rtl/vstripe_pkg.sv
`timescale 1ns/1ps
package vstripe_pkg;

    localparam int PE_W = 8;

    typedef enum logic [2:0] {
        OP_PASS = 3'd0,
        OP_ADD  = 3'd1,
        OP_SUB  = 3'd2,
        OP_AND  = 3'd3,
        OP_OR   = 3'd4,
        OP_XOR  = 3'd5,
        OP_SHL  = 3'd6,
        OP_SHR  = 3'd7
    } pe_op_e;

    typedef struct packed {
        pe_op_e            op;
        logic [PE_W-1:0]   imm;
    } stage_cfg_t;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_RUN   = 2'd1,
        SEQ_DRAIN = 2'd2
    } seq_state_e;

endpackage

// File: rtl/vstripe_pe.sv
`timescale 1ns/1ps
// One byte-wide ALU processing element.
module vstripe_pe
    import vstripe_pkg::*;
(
    input  pe_op_e            op,
    input  logic [PE_W-1:0]   imm,
    input  logic [PE_W-1:0]   a,
    output logic [PE_W-1:0]   y
);
    always_comb begin
        unique case (op)
            OP_PASS: y = a;
            OP_ADD:  y = a + imm;
            OP_SUB:  y = a - imm;
            OP_AND:  y = a & imm;
            OP_OR:   y = a | imm;
            OP_XOR:  y = a ^ imm;
            OP_SHL:  y = a << imm[2:0];
            OP_SHR:  y = a >> imm[2:0];
        endcase
    end
endmodule

// File: rtl/vstripe_cfg_store.sv
`timescale 1ns/1ps
// Stage configuration store: flop array, write port, combinational read.
module vstripe_cfg_store
    import vstripe_pkg::*;
#(
    parameter  int DEPTH  = 16,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  stage_cfg_t        wr_cfg,
    input  logic [ADDR_W-1:0] rd_addr,
    output stage_cfg_t        rd_cfg
);
    stage_cfg_t mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (wr_en) begin
            mem_q[wr_addr] <= wr_cfg;
        end
    end

    assign rd_cfg = mem_q[rd_addr];

    // R2: an accepted write is visible in the addressed slot next cycle
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> mem_q[$past(wr_addr)] == $past(wr_cfg));

    // R2: without a write the word read at a fixed address does not move
    a_r2_read_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wr_en) && rd_addr == $past(rd_addr)) |-> rd_cfg == $past(rd_cfg));
endmodule

// File: rtl/vstripe_ctrl.sv
`timescale 1ns/1ps
// Sequencer state machine plus the stage and stripe pointers.
module vstripe_ctrl
    import vstripe_pkg::*;
#(
    parameter  int ROWS   = 4,
    parameter  int DEPTH  = 16,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [CNT_W-1:0]  stage_cnt,
    input  logic              any_valid,
    output seq_state_e        state,
    output logic              busy,
    output logic              cfg_open,
    output logic              in_ok,
    output logic              clear,
    output logic [ROW_W-1:0]  ld_row,
    output logic [ADDR_W-1:0] ld_stage,
    output logic [ADDR_W-1:0] n_last
);
    seq_state_e        state_q, state_d;
    logic [ADDR_W-1:0] stg_q, n_last_q;
    logic [ROW_W-1:0]  row_q;
    logic              legal;

    assign legal = (stage_cnt >= CNT_W'(ROWS)) && (stage_cnt <= CNT_W'(DEPTH));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE:  if (go && legal) state_d = SEQ_RUN;
            SEQ_RUN:   if (!go)         state_d = SEQ_DRAIN;
            SEQ_DRAIN: if (!any_valid)  state_d = SEQ_IDLE;
            default:                    state_d = SEQ_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    // state-decoded outputs
    always_comb begin
        busy     = 1'b0;
        cfg_open = 1'b0;
        in_ok    = 1'b0;
        clear    = 1'b0;
        unique case (state_q)
            SEQ_IDLE:  begin cfg_open = 1'b1; clear = 1'b1; end
            SEQ_RUN:   begin busy = 1'b1; in_ok = 1'b1; end
            SEQ_DRAIN: busy = 1'b1;
            default:   clear = 1'b1;
        endcase
    end

    // stage pointer modulo N, stripe pointer modulo P
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q    <= '0;
            row_q    <= '0;
            n_last_q <= '0;
        end else if (state_q == SEQ_IDLE) begin
            if (go && legal) begin
                stg_q    <= '0;
                row_q    <= '0;
                n_last_q <= ADDR_W'(stage_cnt - CNT_W'(1));
            end
        end else begin
            stg_q <= (stg_q == n_last_q) ? '0 : stg_q + 1'b1;
            row_q <= (row_q == ROW_W'(ROWS - 1)) ? '0 : row_q + 1'b1;
        end
    end

    assign state    = state_q;
    assign ld_row   = row_q;
    assign ld_stage = stg_q;
    assign n_last   = n_last_q;

    // R3: Run never proceeds with fewer stages than stripes
    a_r3_run_depth_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_RUN) |-> (n_last_q >= ADDR_W'(ROWS - 1)));

    // R8: the stage pointer stays inside the configured depth
    a_r8_stage_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (stg_q <= n_last_q));

    // R9: draining never resumes intake
    a_r9_drain_no_resume: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_DRAIN) |=> (state_q != SEQ_RUN));
endmodule

// File: rtl/vstripe_row.sv
`timescale 1ns/1ps
// One physical stripe: resident stage word, stage tag, data and valid.
module vstripe_row
    import vstripe_pkg::*;
#(
    parameter  int LANES  = 4,
    parameter  int DEPTH  = 16,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int DATA_W = LANES * PE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              load,
    input  stage_cfg_t        load_cfg,
    input  logic [ADDR_W-1:0] load_tag,
    input  logic [DATA_W-1:0] prev_data,
    input  logic              prev_valid,
    input  logic [DATA_W-1:0] ext_data,
    input  logic              ext_ok,
    output logic [DATA_W-1:0] data,
    output logic              valid,
    output logic [ADDR_W-1:0] tag,
    output logic              active,
    output logic              takes
);
    stage_cfg_t        cfg_q, cfg_cur;
    logic [ADDR_W-1:0] tag_q, tag_cur;
    logic [DATA_W-1:0] data_q, src, res;
    logic              valid_q, active_q, live, head, src_v;

    // a stripe rewritten this cycle computes with its new stage at once
    assign cfg_cur = load ? load_cfg : cfg_q;
    assign tag_cur = load ? load_tag : tag_q;
    assign live    = load | active_q;
    assign head    = (tag_cur == '0);
    assign src     = head ? ext_data : prev_data;
    assign src_v   = head ? ext_ok   : prev_valid;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        vstripe_pe u_pe (
            .op  (cfg_cur.op),
            .imm (cfg_cur.imm),
            .a   (src[l*PE_W +: PE_W]),
            .y   (res[l*PE_W +: PE_W])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q    <= '0;
            tag_q    <= '0;
            data_q   <= '0;
            valid_q  <= 1'b0;
            active_q <= 1'b0;
        end else if (clear) begin
            valid_q  <= 1'b0;
            active_q <= 1'b0;
        end else begin
            if (load) begin
                cfg_q    <= load_cfg;
                tag_q    <= load_tag;
                active_q <= 1'b1;
            end
            if (live) begin
                data_q  <= res;
                valid_q <= src_v;
            end
        end
    end

    assign data   = data_q;
    assign valid  = valid_q;
    assign tag    = tag_q;
    assign active = active_q;
    assign takes  = live & head;
endmodule

// File: rtl/vstripe_engine.sv
`timescale 1ns/1ps
// Top: configuration store, sequencer and a ring of ROWS stripes.
module vstripe_engine
    import vstripe_pkg::*;
#(
    parameter  int ROWS   = 4,
    parameter  int LANES  = 4,
    parameter  int DEPTH  = 16,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int DATA_W = LANES * PE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [2:0]        cfg_op,
    input  logic [PE_W-1:0]   cfg_imm,
    input  logic [CNT_W-1:0]  stage_cnt,
    input  logic              go,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_take,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    seq_state_e        state;
    logic              busy, cfg_open, in_ok, clear, any_valid;
    logic [ROW_W-1:0]  ld_row;
    logic [ADDR_W-1:0] ld_stage, n_last;
    stage_cfg_t        wr_cfg, rd_cfg;

    logic [DATA_W-1:0] data_a [ROWS];
    logic [ADDR_W-1:0] tag_a  [ROWS];
    logic [ROWS-1:0]   val_v, act_v, take_v, hit_v;

    assign wr_cfg = '{op: pe_op_e'(cfg_op), imm: cfg_imm};

    vstripe_cfg_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we & cfg_open),
        .wr_addr (cfg_addr),
        .wr_cfg  (wr_cfg),
        .rd_addr (ld_stage),
        .rd_cfg  (rd_cfg)
    );

    vstripe_ctrl #(.ROWS(ROWS), .DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .stage_cnt (stage_cnt),
        .any_valid (any_valid),
        .state     (state),
        .busy      (busy),
        .cfg_open  (cfg_open),
        .in_ok     (in_ok),
        .clear     (clear),
        .ld_row    (ld_row),
        .ld_stage  (ld_stage),
        .n_last    (n_last)
    );

    for (genvar i = 0; i < ROWS; i++) begin : g_row
        localparam int PREV = (i + ROWS - 1) % ROWS;
        vstripe_row #(.LANES(LANES), .DEPTH(DEPTH)) u_row (
            .clk        (clk),
            .rst_n      (rst_n),
            .clear      (clear),
            .load       (busy && (ld_row == ROW_W'(i))),
            .load_cfg   (rd_cfg),
            .load_tag   (ld_stage),
            .prev_data  (data_a[PREV]),
            .prev_valid (val_v[PREV]),
            .ext_data   (in_data),
            .ext_ok     (in_ok),
            .data       (data_a[i]),
            .valid      (val_v[i]),
            .tag        (tag_a[i]),
            .active     (act_v[i]),
            .takes      (take_v[i])
        );
        assign hit_v[i] = act_v[i] & val_v[i] & (tag_a[i] == n_last);
    end

    assign any_valid = |(val_v & act_v);
    assign in_take   = in_ok & (|take_v);
    assign out_valid = |hit_v;

    always_comb begin
        out_data = '0;
        for (int i = 0; i < ROWS; i++) begin
            if (hit_v[i]) out_data = out_data | data_a[i];
        end
    end

    // checker view of the stripe about to be rewritten
    logic [ADDR_W-1:0] victim_tag;
    logic              victim_act;
    logic [ADDR_W+1:0] vic_sum, vic_mod, n_full;
    always_comb begin
        victim_tag = '0;
        victim_act = 1'b0;
        for (int i = 0; i < ROWS; i++) begin
            if (ld_row == ROW_W'(i)) begin
                victim_tag = tag_a[i];
                victim_act = act_v[i];
            end
        end
        n_full  = (ADDR_W+2)'(n_last) + (ADDR_W+2)'(1);
        vic_sum = (ADDR_W+2)'(victim_tag) + (ADDR_W+2)'(ROWS);
        vic_mod = (vic_sum >= n_full) ? vic_sum - n_full : vic_sum;
    end

    // R8: the stripe overwritten is the one that finished stage (new - P) mod N
    a_r8_evict_finished: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && victim_act) |-> (vic_mod == (ADDR_W+2)'(ld_stage)));

    // R7: at most one stripe sits at the input head
    a_r7_single_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(take_v));

    // R5: at most one stripe drives the output
    a_r5_single_exit: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_v));

    // R9: Idle neither takes nor emits
    a_r9_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_IDLE) |-> (!in_take && !out_valid));
endmodule

// File: tb/test_vstripe_engine.sv
`timescale 1ns/1ps
module test_vstripe_engine;
    localparam int P = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [2:0]  cfg_op = '0;
    logic [7:0]  cfg_imm = '0;
    logic [4:0]  stage_cnt = 5'd4;
    logic        go = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_take, out_valid;
    logic [31:0] out_data;

    vstripe_engine i_vstripe_engine (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_op(cfg_op), .cfg_imm(cfg_imm), .stage_cnt(stage_cnt), .go(go),
        .in_data(in_data), .in_take(in_take), .out_valid(out_valid), .out_data(out_data)
    );

    always #2.5 clk = ~clk;

    int n_checks = 0, n_errs = 0, cyc = 0, cur_n = 4;
    logic [2:0]  m_op  [16];
    logic [7:0]  m_imm [16];
    logic [31:0] exp_data [0:1023];
    int          exp_due  [0:1023];
    int          head = 0, tail = 0;
    logic [31:0] lfsr = 32'h1234_5678;
    string       cur_req = "R5 R8";

    // {N, opcode seed, immediate seed, Run length}
    localparam int SCN [6][4] = '{
        '{4,  1,  3, 20},
        '{5,  2,  7, 23},
        '{8,  0, 11, 30},
        '{13, 5, 29, 40},
        '{16, 3, 53, 50},
        '{6,  7, 97,  9}
    };

    function automatic logic [7:0] alu(input logic [2:0] op, input logic [7:0] imm,
                                       input logic [7:0] a);
        case (op)
            3'd0: return a;
            3'd1: return a + imm;
            3'd2: return a - imm;
            3'd3: return a & imm;
            3'd4: return a | imm;
            3'd5: return a ^ imm;
            3'd6: return a << imm[2:0];
            default: return a >> imm[2:0];
        endcase
    endfunction

    function automatic logic [31:0] model(input logic [31:0] w);
        logic [31:0] r = w;
        for (int k = 0; k < cur_n; k++)
            for (int l = 0; l < 4; l++)
                r[8*l +: 8] = alu(m_op[k], m_imm[k], r[8*l +: 8]);
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s: got %h expected %h (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    // one clock: check output, drive next input, advance to next negedge
    task automatic tick();
        if (out_valid) begin
            if (head < tail) begin
                chk(exp_due[head] == cyc && out_data == exp_data[head], cur_req,
                    out_data, exp_data[head]);
                head++;
            end else begin
                chk(1'b0, "R5 unexpected output", out_data, 32'h0);
            end
        end else if (head < tail && exp_due[head] == cyc) begin
            chk(1'b0, "R6 missing output", 32'h0, exp_data[head]);
            head++;
        end
        lfsr = lfsr ^ (lfsr << 13);
        lfsr = lfsr ^ (lfsr >> 17);
        lfsr = lfsr ^ (lfsr << 5);
        in_data = lfsr;
        if (in_take) begin
            exp_data[tail] = model(in_data);
            exp_due[tail]  = cyc + cur_n;
            tail++;
        end
        @(posedge clk);
        @(negedge clk);
        cyc++;
    endtask

    task automatic write_stage(input int a, input logic [2:0] op, input logic [7:0] imm);
        cfg_we = 1'b1; cfg_addr = 4'(a); cfg_op = op; cfg_imm = imm;
        m_op[a] = op; m_imm[a] = imm;
        @(posedge clk); @(negedge clk); cyc++;
        cfg_we = 1'b0;
    endtask

    task automatic run_scn(input int n, input int len, input int wr_at);
        stage_cnt = 5'(n);
        cur_n = n;
        head = 0; tail = 0;
        go = 1'b1;
        tick();
        for (int t = 0; t < len; t++) begin
            chk(in_take == ((t % n) < P), "R7 intake pattern", 32'(in_take), 32'((t % n) < P));
            if (t == len - 1) go = 1'b0;
            if (t == wr_at) begin
                cfg_we = 1'b1; cfg_addr = 4'd0; cfg_op = 3'd5; cfg_imm = 8'hFF;
            end
            tick();
            cfg_we = 1'b0;
        end
        for (int d = 0; d < n + P + 3; d++) begin
            chk(!in_take, "R9 no intake while draining", 32'(in_take), 32'h0);
            tick();
        end
        chk(head == tail, "R9 all words delivered", 32'(head), 32'(tail));
        chk(!out_valid && !in_take, "R9 idle after drain", 32'(out_valid), 32'h0);
    endtask

    initial begin
        for (int k = 0; k < 16; k++) begin m_op[k] = '0; m_imm[k] = '0; end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!out_valid, "R1 out_valid in reset", 32'(out_valid), 32'h0);
        chk(!in_take, "R1 in_take in reset", 32'(in_take), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid && !in_take, "R1 idle after reset", 32'(out_valid), 32'h0);

        // table-driven scenarios: depth, opcode mix, run length
        for (int s = 0; s < 6; s++) begin
            for (int k = 0; k < SCN[s][0]; k++)
                write_stage(k, 3'((SCN[s][1] + 3 * k) % 8), 8'((SCN[s][2] * (k + 1) + k) % 256));
            cur_req = "R5 R8 result";
            run_scn(SCN[s][0], SCN[s][3], -1);
        end

        // R4: each opcode alone in stage 0, remaining stages pass
        for (int op = 0; op < 8; op++) begin
            write_stage(0, 3'(op), 8'hA5);
            for (int k = 1; k < 4; k++) write_stage(k, 3'd0, 8'h00);
            cur_req = "R4 opcode";
            run_scn(4, 4, -1);
        end

        // R2: writes during Run are ignored, now and in the next run
        for (int k = 0; k < 6; k++) write_stage(k, 3'd1, 8'(k + 1));
        cur_req = "R2 write during run ignored";
        run_scn(6, 18, 5);
        run_scn(6, 8, -1);

        // R3: illegal depths refuse to start
        foreach (SCN[0][j]) begin end
        for (int b = 0; b < 3; b++) begin
            stage_cnt = (b == 0) ? 5'd3 : (b == 1) ? 5'd17 : 5'd0;
            go = 1'b1;
            for (int c = 0; c < 6; c++) begin
                tick();
                chk(!in_take && !out_valid, "R3 illegal depth refused", 32'(in_take), 32'h0);
            end
            go = 1'b0;
            tick();
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        n_checks++;
        n_errs++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end
endmodule